// File: doc/BRIEF.md
# Twelve-Function 8-bit Arithmetic and Logic Unit

This block is the combinational arithmetic and logic unit of a small accumulator-style microcontroller core. It takes two operands, a carry flag value and a 4-bit function code. In the same cycle it returns a result, a new carry value and a zero indication. The surrounding core owns the flag register and the operand selection. The unit only computes.

The twelve functions cover four kinds of work. There are bitwise logic operations, and there is addition and subtraction with increment and decrement. Either operand can be passed straight through. The accumulator can be rotated one place left or right, with the carry flag taking part in the rotation.

The adder path can be built as one full-width adder. It can also be built as a chain of narrower slices, where each slice hands its carry to the next one up. The default builds two 4-bit slices. A parameter selects between the two forms, and both forms give the same results.

Top module: `acc_alu`

## Requirements
- R1: Code 0 gives F = ~A, code 1 gives F = A & B, code 2 gives F = A | B and code 3 gives F = A ^ B.
- R2: Code 4 gives F = (A + B) mod 256, with carry out set when A + B exceeds 255. The carry input has no effect on this result.
- R3: Code 5 gives F = (A - B) mod 256, with carry out set when A >= B, meaning no borrow occurred.
- R4: Code 6 gives F = (A + 1) mod 256, with carry out set only for A = 0xFF. Code 7 gives F = (A - 1) mod 256, with carry out set only when A is not 0x00.
- R5: Code 8 gives F = A and code 9 gives F = B.
- R6: Code 10 rotates left through carry: F = {A[6:0], Cin} and carry out = A[7].
- R7: Code 11 rotates right through carry: F = {Cin, A[7:1]} and carry out = A[0].
- R8: Codes 12 to 15 give F = 0x00, with carry out equal to the carry input.
- R9: Codes 0 to 3, 8 and 9 drive carry out equal to the carry input.
- R10: For every code, the zero output is 1 exactly when F = 0x00.
- R11: The sliced adder build and the single-adder build give identical F, carry and zero for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand (accumulator side) |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Function code |
| f_o | output | 8 | Result |
| carry_o | output | 1 | New carry value |
| zero_o | output | 1 | High when the result is zero |

## Verification
The unit holds no state, so a fault shows up on the outputs in the same evaluation as the input that exposes it. The faults most likely to hide are an inter-slice carry that is dropped or stuck, and a borrow sense that is inverted. A dropped or stuck carry shows as a wrong upper nibble only for sums that cross the 4-bit boundary. An inverted borrow sense flips the carry for subtraction and decrement. For these reasons the corner operands 0x00, 0x7F, 0x80 and 0xFF are applied under every code and both carry inputs. The two builds are also compared side by side.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    FN_NOT  = 4'd0,
    FN_AND  = 4'd1,
    FN_OR   = 4'd2,
    FN_XOR  = 4'd3,
    FN_ADD  = 4'd4,
    FN_SUB  = 4'd5,
    FN_INC  = 4'd6,
    FN_DEC  = 4'd7,
    FN_PSA  = 4'd8,
    FN_PSB  = 4'd9,
    FN_ROL  = 4'd10,
    FN_ROR  = 4'd11
  } alu_fn_e;

  function automatic logic is_arith(input logic [3:0] op);
    return (op >= 4'd4) && (op <= 4'd7);
  endfunction
endpackage

// File: rtl/acc_alu_add_slice.sv
module acc_alu_add_slice #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] x_i,
  input  logic [SW-1:0] y_i,
  input  logic          c_i,
  output logic [SW-1:0] s_o,
  output logic          c_o
);
  logic [SW:0] total;
  always_comb begin
    total = {1'b0, x_i} + {1'b0, y_i} + {{SW{1'b0}}, c_i};
    s_o   = total[SW-1:0];
    c_o   = total[SW];
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W      = 8,
  parameter int SW     = 4,
  parameter bit SLICED = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  localparam int NS = W / SW;

  logic [W-1:0] y_op;
  logic         c_in0;

  // Operand shaping: the subtract path adds ~B plus one, so a carry out of 1 means no borrow.
  always_comb begin
    y_op  = '0;
    c_in0 = 1'b0;
    case (op_i)
      FN_ADD: begin y_op = b_i;  c_in0 = 1'b0; end
      FN_SUB: begin y_op = ~b_i; c_in0 = 1'b1; end
      FN_INC: begin y_op = '0;   c_in0 = 1'b1; end
      FN_DEC: begin y_op = '1;   c_in0 = 1'b0; end
      default: begin y_op = '0;  c_in0 = 1'b0; end
    endcase
  end

  generate
    if (SLICED) begin : g_chain
      logic [NS:0] cc;
      assign cc[0] = c_in0;
      for (genvar k = 0; k < NS; k++) begin : g_sl
        acc_alu_add_slice #(.SW(SW)) u_sl (
          .x_i (a_i[k*SW +: SW]),
          .y_i (y_op[k*SW +: SW]),
          .c_i (cc[k]),
          .s_o (s_o[k*SW +: SW]),
          .c_o (cc[k+1])
        );
      end
      assign c_o = cc[NS];
    end else begin : g_flat
      acc_alu_add_slice #(.SW(W)) u_full (
        .x_i (a_i),
        .y_i (y_op),
        .c_i (c_in0),
        .s_o (s_o),
        .c_o (c_o)
      );
    end
  endgenerate

  // R3: borrow sense of the chained result against a direct magnitude compare
  always_comb begin
    if (op_i == FN_SUB) begin
      a_sub_borrow_r3: assert (c_o == (a_i >= b_i))
        else $error("subtract carry does not match A>=B");
    end
    if (op_i == FN_DEC) begin
      a_dec_carry_r4: assert (c_o == (a_i != '0))
        else $error("decrement carry does not match A!=0");
    end
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] f_o,
  output logic         c_o
);
  always_comb begin
    f_o = '0;
    c_o = c_i;
    case (op_i)
      FN_NOT: f_o = ~a_i;
      FN_AND: f_o = a_i & b_i;
      FN_OR:  f_o = a_i | b_i;
      FN_XOR: f_o = a_i ^ b_i;
      FN_PSA: f_o = a_i;
      FN_PSB: f_o = b_i;
      FN_ROL: begin f_o = {a_i[W-2:0], c_i}; c_o = a_i[W-1]; end
      FN_ROR: begin f_o = {c_i, a_i[W-1:1]}; c_o = a_i[0];   end
      default: begin f_o = '0; c_o = c_i; end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W      = 8,
  parameter int SW     = 4,
  parameter bit SLICED = 1'b1
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] f_o,
  output logic         carry_o,
  output logic         zero_o
);
  logic [W-1:0] ar_f, lg_f;
  logic         ar_c, lg_c;

  acc_alu_arith #(.W(W), .SW(SW), .SLICED(SLICED)) u_arith (
    .a_i (a_i), .b_i (b_i), .op_i (op_i), .s_o (ar_f), .c_o (ar_c)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .a_i (a_i), .b_i (b_i), .c_i (carry_i), .op_i (op_i), .f_o (lg_f), .c_o (lg_c)
  );

  always_comb begin
    if (is_arith(op_i)) begin
      f_o     = ar_f;
      carry_o = ar_c;
    end else begin
      f_o     = lg_f;
      carry_o = lg_c;
    end
    zero_o = ~|f_o;
  end

  always_comb begin
    if (op_i >= 4'd12) begin
      a_reserved_r8: assert ((f_o == '0) && (carry_o == carry_i))
        else $error("reserved code changed result or carry");
    end
    if ((op_i <= 4'd3) || (op_i == 4'd8) || (op_i == 4'd9)) begin
      a_carry_hold_r9: assert (carry_o == carry_i)
        else $error("logic or pass code altered carry");
    end
    if (op_i == FN_ROL) begin
      a_rol_carry_r6: assert ((carry_o == a_i[W-1]) && (f_o[0] == carry_i))
        else $error("rotate left carry path wrong");
    end
    if (op_i == FN_ROR) begin
      a_ror_carry_r7: assert ((carry_o == a_i[0]) && (f_o[W-1] == carry_i))
        else $error("rotate right carry path wrong");
    end
    if (op_i == FN_ADD) begin
      a_add_sum_r2: assert ({carry_o, f_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("add result mismatch");
    end
    a_zero_flag_r10: assert (!(zero_o && (f_o != '0)))
      else $error("zero flag set with nonzero result");
  end
endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a, b;
  logic       cin;
  logic [3:0] op;
  logic [7:0] f_s, f_f;
  logic       c_s, c_f, z_s, z_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  acc_alu #(.W(8), .SW(4), .SLICED(1'b1)) dut_i (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .f_o(f_s), .carry_o(c_s), .zero_o(z_s)
  );

  acc_alu #(.W(8), .SW(4), .SLICED(1'b0)) dut_flat_i (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op),
    .f_o(f_f), .carry_o(c_f), .zero_o(z_f)
  );

  // Expected {zero, carry, f}, computed from the requirements.
  function automatic logic [9:0] model(input logic [3:0] o, input logic [7:0] x,
                                       input logic [7:0] y, input logic ci);
    logic [7:0] r;
    logic       c;
    int         t;
    c = ci;
    r = 8'h00;
    case (o)
      4'd0: r = ~x;
      4'd1: r = x & y;
      4'd2: r = x | y;
      4'd3: r = x ^ y;
      4'd4: begin t = int'(x) + int'(y); r = t[7:0]; c = (t > 255); end
      4'd5: begin t = int'(x) - int'(y); r = t[7:0]; c = (int'(x) >= int'(y)); end
      4'd6: begin t = int'(x) + 1; r = t[7:0]; c = (x == 8'hFF); end
      4'd7: begin t = int'(x) - 1; r = t[7:0]; c = (x != 8'h00); end
      4'd8: r = x;
      4'd9: r = y;
      4'd10: begin r = {x[6:0], ci}; c = x[7]; end
      4'd11: begin r = {ci, x[7:1]}; c = x[0]; end
      default: begin r = 8'h00; c = ci; end
    endcase
    return {(r == 8'h00), c, r};
  endfunction

  task automatic apply_check(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                             input logic ci, input string tag);
    logic [9:0] e;
    @(posedge clk);
    op = o; a = x; b = y; cin = ci;
    @(negedge clk);
    e = model(o, x, y, ci);
    checks++;
    if ({z_s, c_s, f_s} !== e) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b actual z=%b c=%b f=%h expected z=%b c=%b f=%h",
               tag, o, x, y, ci, z_s, c_s, f_s, e[9], e[8], e[7:0]);
    end
    checks++;
    if ({z_f, c_f, f_f} !== {z_s, c_s, f_s}) begin
      fails++;
      $display("FAIL R11 op=%0d a=%h b=%h cin=%b actual sliced=%b%b%h expected flat=%b%b%h",
               o, x, y, ci, z_s, c_s, f_s, z_f, c_f, f_f);
    end
  endtask

  function automatic logic [7:0] corner(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      4: return 8'h0F;
      default: return 8'h01;
    endcase
  endfunction

  task automatic t_initial;
    apply_check(4'd0, 8'h00, 8'h00, 1'b0, "R1");
  endtask

  task automatic t_code_sweep(input logic [3:0] o, input string tag);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int c = 0; c < 2; c++)
          apply_check(o, corner(i), corner(j), c[0], tag);
  endtask

  task automatic t_logic;  // R1 R9
    t_code_sweep(4'd0, "R1"); t_code_sweep(4'd1, "R1");
    t_code_sweep(4'd2, "R9"); t_code_sweep(4'd3, "R9");
  endtask

  task automatic t_add;    // R2: nibble boundary crossing, cin ignored
    t_code_sweep(4'd4, "R2");
    apply_check(4'd4, 8'h0F, 8'h01, 1'b1, "R2");
    apply_check(4'd4, 8'hFF, 8'h01, 1'b0, "R2");
  endtask

  task automatic t_sub;    // R3
    t_code_sweep(4'd5, "R3");
    apply_check(4'd5, 8'h10, 8'h01, 1'b0, "R3");
    apply_check(4'd5, 8'h42, 8'h42, 1'b0, "R3");
  endtask

  task automatic t_incdec; // R4
    t_code_sweep(4'd6, "R4"); t_code_sweep(4'd7, "R4");
  endtask

  task automatic t_pass;   // R5
    t_code_sweep(4'd8, "R5"); t_code_sweep(4'd9, "R5");
  endtask

  task automatic t_rot;    // R6 R7
    t_code_sweep(4'd10, "R6"); t_code_sweep(4'd11, "R7");
  endtask

  task automatic t_reserved; // R8
    for (int o = 12; o < 16; o++) t_code_sweep(o[3:0], "R8");
  endtask

  task automatic t_zero;   // R10
    apply_check(4'd3, 8'h5A, 8'h5A, 1'b1, "R10");
    apply_check(4'd4, 8'h80, 8'h80, 1'b0, "R10");
    apply_check(4'd11, 8'h01, 8'h00, 1'b0, "R10");
  endtask

  task automatic t_random; // R11 across all codes
    for (int n = 0; n < 800; n++)
      apply_check(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
                  1'($urandom), "R11");
  endtask

  initial begin
    a = 8'h00; b = 8'h00; cin = 1'b0; op = 4'd0;
    t_initial;
    t_logic;
    t_add;
    t_sub;
    t_incdec;
    t_pass;
    t_rot;
    t_reserved;
    t_zero;
    t_random;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule